// File: doc/BRIEF.md
# External Bus Cycle Priority Arbiter

This block decides which of four masters owns the single external bus. The masters are an outside device asking to take the bus over (hold), the DMA controller, CPU operand loads and stores, and CPU instruction fetch. The outcome is a registered one-hot grant, a hold acknowledge and an idle flag. The bus interface pulses a done strobe when a bus cycle finishes, and the grant is reconsidered only at that point or while the bus is free. A cycle that is already running is never taken away. A hold grant stays in place for as long as the outside device keeps its request up.

Outside a protected sequence the order is fixed: hold first, then DMA, then operand access, then instruction fetch. While the CPU signals a bus lock, or a read-modify-write is in progress, hold and DMA requests are held back. The CPU keeps the bus through the protected sequence, and an instruction fetch can still be placed between its accesses, for example between the read and the write halves of a read-modify-write. Requests are level signals that stay asserted until they are served.

Top module: `bus_prio_arb`

## Requirements
- R1: `grant` is one-hot or zero, with bit 0 = hold, bit 1 = DMA, bit 2 = operand access and bit 3 = instruction fetch.
- R2: Outside a lock or read-modify-write window, a decision grants the highest pending request in the order hold, DMA, operand, fetch.
- R3: A decision is taken at a rising edge when the bus is free, when a non-hold owner sees `cyc_done` high, or when a hold owner sees `hold_req` low. The new grant is visible right after that edge.
- R4: A DMA, operand or fetch grant is kept unchanged until `cyc_done` is sampled high, whatever other requests arrive.
- R5: While `cpu_lock` or `rmw_busy` is high, a decision never grants hold or DMA.
- R6: Inside such a window, an instruction fetch is granted when no operand request is pending, and an operand request beats a fetch.
- R7: A hold grant ignores `cyc_done` and persists while `hold_req` stays high. `hold_ack` equals grant bit 0. When `hold_req` drops, the next owner is decided at that same edge.
- R8: A decision with no pending request leaves `grant` zero, and `idle` is high exactly when `grant` is zero.
- R9: While `rst_n` is low, `grant` is zero, `hold_ack` is low and `idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| hold_req | input | 1 | Outside device asks to take over the bus |
| dma_req | input | 1 | DMA controller bus request |
| opnd_req | input | 1 | CPU operand access request |
| fetch_req | input | 1 | CPU instruction fetch request |
| cpu_lock | input | 1 | CPU holds the bus lock |
| rmw_busy | input | 1 | A read-modify-write sequence is in progress |
| cyc_done | input | 1 | Current bus cycle completes this clock |
| grant | output | 4 | One-hot owner: bit0 hold, bit1 DMA, bit2 operand, bit3 fetch |
| hold_ack | output | 1 | Bus handed to the outside device |
| idle | output | 1 | No owner on the bus |

## Verification
Every output comes from one register stage. A decision taken at a rising edge therefore shows on `grant`, `hold_ack` and `idle` at that edge, and nothing is due in any later cycle. The bench changes its inputs a quarter period after each rising edge. Its behavioural model takes its step at the rising edge, and all outputs are compared with the model at that quarter-period point on every clock. The scenarios then target the decision points: a pending request while the owner has no done strobe, a hold released with other requests queued, and windows opening and closing around operand and fetch traffic.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
   localparam int unsigned SRC_COUNT = 4;
   localparam int unsigned SRC_HOLD  = 0;
   localparam int unsigned SRC_DMA   = 1;
   localparam int unsigned SRC_OPND  = 2;
   localparam int unsigned SRC_FETCH = 3;
   typedef logic [SRC_COUNT-1:0] src_vec_t;
endpackage

// File: rtl/bpa_window_mask.sv
module bpa_window_mask #(
   parameter int unsigned WIDTH = 4,
   parameter logic [WIDTH-1:0] BLOCK = '0
) (
   input  logic [WIDTH-1:0] req_in,
   input  logic             window,
   output logic [WIDTH-1:0] req_out
);
   if (WIDTH < 2) begin : g_bad_width
      $error("bpa_window_mask: WIDTH must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (BLOCK[i]) begin : g_gated
         assign req_out[i] = req_in[i] & ~window;
      end else begin : g_pass
         assign req_out[i] = req_in[i];
      end
   end
endmodule

// File: rtl/bpa_fixed_prio.sv
module bpa_fixed_prio #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] req,
   output logic [WIDTH-1:0] pick
);
   if (WIDTH < 2) begin : g_bad_width
      $error("bpa_fixed_prio: WIDTH must be at least 2");
   end

   // lowest index wins
   always_comb begin
      logic taken;
      taken = 1'b0;
      pick  = '0;
      for (int i = 0; i < WIDTH; i++) begin
         pick[i] = req[i] & ~taken;
         taken   = taken | req[i];
      end
   end
endmodule

// File: rtl/bpa_grant_ctl.sv
module bpa_grant_ctl #(
   parameter int unsigned WIDTH    = 4,
   parameter int unsigned HOLD_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pick,
   input  logic             hold_req,
   input  logic             cyc_done,
   output logic [WIDTH-1:0] grant_q
);
   if (HOLD_IDX >= WIDTH) begin : g_bad_idx
      $error("bpa_grant_ctl: HOLD_IDX out of range");
   end

   logic on_hold;
   logic busy;
   logic decide;

   assign on_hold = grant_q[HOLD_IDX];
   assign busy    = |grant_q;
   assign decide  = !busy || (on_hold ? !hold_req : cyc_done);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= '0;
      end else if (decide) begin
         grant_q <= pick;
      end
   end

   assert_no_preempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !on_hold && !cyc_done) |=> $stable(grant_q));

   assert_hold_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (on_hold && hold_req) |=> grant_q[HOLD_IDX]);
endmodule

// File: rtl/bus_prio_arb.sv
module bus_prio_arb
   import bpa_pkg::*;
#(
   parameter src_vec_t WINDOW_BLOCK = src_vec_t'(4'b0011)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_req,
   input  logic       dma_req,
   input  logic       opnd_req,
   input  logic       fetch_req,
   input  logic       cpu_lock,
   input  logic       rmw_busy,
   input  logic       cyc_done,
   output logic [3:0] grant,
   output logic       hold_ack,
   output logic       idle
);
   localparam int unsigned W = SRC_COUNT;

   if (W != 4) begin : g_bad_count
      $error("bus_prio_arb: exactly four sources expected");
   end
   if (WINDOW_BLOCK[SRC_FETCH] || WINDOW_BLOCK[SRC_OPND]) begin : g_bad_mask
      $error("bus_prio_arb: CPU sources must stay open inside a window");
   end

   src_vec_t req_raw;
   src_vec_t req_open;
   src_vec_t pick;
   src_vec_t grant_q;
   logic     window;

   assign req_raw[SRC_HOLD]  = hold_req;
   assign req_raw[SRC_DMA]   = dma_req;
   assign req_raw[SRC_OPND]  = opnd_req;
   assign req_raw[SRC_FETCH] = fetch_req;
   assign window = cpu_lock | rmw_busy;

   bpa_window_mask #(.WIDTH(W), .BLOCK(WINDOW_BLOCK)) u_mask (
      .req_in (req_raw),
      .window (window),
      .req_out(req_open)
   );

   bpa_fixed_prio #(.WIDTH(W)) u_prio (
      .req (req_open),
      .pick(pick)
   );

   bpa_grant_ctl #(.WIDTH(W), .HOLD_IDX(SRC_HOLD)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .pick    (pick),
      .hold_req(hold_req),
      .cyc_done(cyc_done),
      .grant_q (grant_q)
   );

   assign grant    = grant_q;
   assign hold_ack = grant_q[SRC_HOLD];
   assign idle     = ~|grant_q;

   logic at_decision;
   assign at_decision = (grant == 4'b0000) ||
                        (grant[0] && !hold_req) ||
                        (!grant[0] && cyc_done);

   assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_hold_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (at_decision && hold_req && !cpu_lock && !rmw_busy) |=> grant == 4'b0001);

   assert_dma_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (at_decision && !hold_req && dma_req && !cpu_lock && !rmw_busy) |=> grant == 4'b0010);

   assert_window_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cpu_lock || rmw_busy) && grant[1:0] == 2'b00) |=> grant[1:0] == 2'b00);

   assert_fetch_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (at_decision && (cpu_lock || rmw_busy) && fetch_req && !opnd_req) |=> grant == 4'b1000);

   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (at_decision && !hold_req && !dma_req && !opnd_req && !fetch_req) |=> idle);
endmodule

// File: tb/bus_prio_arb_tb_top.sv
module bus_prio_arb_tb_top;
   localparam time CLK_P = 10ns;
   localparam int  WATCHDOG = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_req = 0, dma_req = 0, opnd_req = 0, fetch_req = 0;
   logic cpu_lock = 0, rmw_busy = 0, cyc_done = 0;
   logic [3:0] grant;
   logic hold_ack, idle;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int exp_owner = -1;   // -1 none, 0 hold, 1 dma, 2 operand, 3 fetch
   string tag = "R9";

   always #(CLK_P/2) clk = ~clk;

   bus_prio_arb dut_i (
      .clk(clk), .rst_n(rst_n),
      .hold_req(hold_req), .dma_req(dma_req), .opnd_req(opnd_req), .fetch_req(fetch_req),
      .cpu_lock(cpu_lock), .rmw_busy(rmw_busy), .cyc_done(cyc_done),
      .grant(grant), .hold_ack(hold_ack), .idle(idle)
   );

   function automatic int choose();
      bit win = cpu_lock || rmw_busy;
      if (!win && hold_req) return 0;
      if (!win && dma_req)  return 1;
      if (opnd_req)         return 2;
      if (fetch_req)        return 3;
      return -1;
   endfunction

   // behavioural reference model
   always @(posedge clk) begin
      if (!rst_n)                            exp_owner <= -1;
      else if (exp_owner == 0)               exp_owner <= hold_req ? 0 : choose();
      else if (exp_owner > 0 && !cyc_done)   exp_owner <= exp_owner;
      else                                   exp_owner <= choose();
   end

   task automatic compare();
      logic [3:0] eg = (exp_owner < 0) ? 4'b0000 : 4'(1 << exp_owner);
      checks++;
      if (grant !== eg) begin
         errors++;
         $display("FAIL %s grant actual=%b expected=%b t=%0t", tag, grant, eg, $time);
      end
      checks++;
      if (hold_ack !== eg[0] || idle !== (eg == 4'b0000)) begin
         errors++;
         $display("FAIL %s ack/idle actual=%b/%b expected=%b/%b", tag, hold_ack, idle,
                  eg[0], (eg == 4'b0000));
      end
      checks++;
      if (!$onehot0(grant)) begin
         errors++;
         $display("FAIL R1 onehot actual=%b expected=onehot0", grant);
      end
   endtask

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #(CLK_P/4);
         compare();
         cycles++;
      end
   endtask

   task automatic set_req(logic h, logic d, logic o, logic f);
      hold_req = h; dma_req = d; opnd_req = o; fetch_req = f;
   endtask

   task automatic expect_grant(logic [3:0] g, string t);
      checks++;
      if (grant !== g) begin
         errors++;
         $display("FAIL %s direct actual=%b expected=%b", t, grant, g);
      end
   endtask

   initial begin
      tag = "R9"; step(3);
      expect_grant(4'b0000, "R9");
      rst_n = 1'b1;
      step(2);

      tag = "R2";
      set_req(1, 1, 1, 1); cyc_done = 1;
      step(1);
      expect_grant(4'b0001, "R2");
      tag = "R7"; step(3);                // hold ignores done
      expect_grant(4'b0001, "R7");
      set_req(0, 1, 1, 1); step(1);       // dma follows at the release edge
      expect_grant(4'b0010, "R7");
      tag = "R2"; set_req(0, 0, 1, 1); step(1);
      expect_grant(4'b0100, "R2");
      set_req(0, 0, 0, 1); step(1);
      expect_grant(4'b1000, "R2");

      tag = "R4"; cyc_done = 0; set_req(1, 1, 0, 1); step(4);
      expect_grant(4'b1000, "R4");
      cyc_done = 1; set_req(1, 1, 0, 0); step(1);
      expect_grant(4'b0001, "R4");
      set_req(0, 0, 0, 0); cyc_done = 0; step(1);

      tag = "R8"; step(2);
      expect_grant(4'b0000, "R8");

      tag = "R3"; set_req(0, 0, 1, 0); step(1);
      expect_grant(4'b0100, "R3");
      set_req(0, 1, 0, 0); step(2);
      cyc_done = 1; step(1);
      expect_grant(4'b0010, "R3");
      set_req(0, 0, 0, 0); step(1);

      tag = "R5"; rmw_busy = 1; cyc_done = 1;
      set_req(1, 1, 1, 0); step(1);       // read half
      expect_grant(4'b0100, "R5");
      tag = "R6"; set_req(1, 1, 0, 1); step(1);
      expect_grant(4'b1000, "R6");
      set_req(1, 1, 1, 1); step(1);       // write half beats fetch
      expect_grant(4'b0100, "R6");
      rmw_busy = 0; set_req(1, 1, 0, 1); step(1);
      expect_grant(4'b0001, "R5");
      set_req(0, 0, 0, 0); step(1);

      tag = "R5"; cpu_lock = 1; set_req(0, 1, 1, 0); step(1);
      expect_grant(4'b0100, "R5");
      tag = "R6"; set_req(1, 1, 0, 1); step(2);
      expect_grant(4'b1000, "R6");
      set_req(1, 1, 0, 0); step(2);
      expect_grant(4'b0000, "R5");
      cpu_lock = 0; step(1);
      expect_grant(4'b0001, "R2");

      tag = "R9"; set_req(0, 1, 0, 0); rst_n = 0; step(2);
      expect_grant(4'b0000, "R9");
      rst_n = 1; tag = "R2"; step(2);
      set_req(0, 0, 0, 0); step(2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule